// File: doc/BRIEF.md
# Chainable memory-to-memory DMA channel

This block is one DMA channel that copies data from one address range to another over a simple request/grant memory bus. It holds four registers: the read address, the write address, the remaining transfer count and a control word. Any agent can write these registers while the channel is idle, and that includes another channel of the same kind. A second channel that streams a four-word image into this one can therefore load it and launch it, so a small fetch/execute machine can be built from channels alone.

A launched channel waits for its selected pacing request before each beat. A beat is one read followed by one write of the chosen size. The addresses advance or stay fixed as the control word says. When the count reaches zero the channel goes idle. In that same cycle it pulses the trigger line of a chosen peer channel and, unless told to stay quiet, raises an interrupt pulse. Each bus cycle also carries a priority flag and a sniffer tag for use by fabric outside the block.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, and whenever the channel is idle, `busy_o` is low and no bus request is made. After reset all four registers read as zero.
- R2: Register index 0 is the read address, 1 the write address, 2 the remaining count and 3 the control word. Only bits 23:0 of the control word are stored; bits 31:24 read as zero. `reg_rdata_o` returns the register selected by `reg_addr_i` in the same cycle and follows the addresses and the count as the transfer progresses.
- R3: When the channel is idle, a write to index 3 or a pulse on `trig_i` starts it, provided the enable bit (control bit 0) is 1. For a write to index 3 the enable bit is taken from the value being written. `busy_o` rises in the next cycle.
- R4: While `busy_o` is high, register writes and `trig_i` are ignored.
- R5: The pacing source is selected by control bits 20:15. Value 0x3f is always ready. Values 0x3b to 0x3e select `timer_i[0]` to `timer_i[3]`. Values below NDREQ select `dreq_i` of that index. Any other value never becomes ready. The source is sampled once per beat, before the read.
- R6: A beat starts when the count is nonzero and the pacing source is ready. The read bus cycle is held until it is granted, then the write bus cycle is held until it is granted. The count then drops by one. When the channel finds the count at zero, including a zero count at start, it goes idle without touching the bus.
- R7: Control bits 3:2 give the size: 0 is byte, 1 is halfword, and 2 or 3 is word. `bus_size_o` carries 0, 1 or 2. Data is right-justified and the bits above the size are written as zero.
- R8: Control bit 4 makes the read address advance and bit 5 makes the write address advance, by 1, 2 or 4 bytes according to the size. When a bit is clear, that address stays fixed.
- R9: Control bits 14:11 name the chain target. In the cycle in which `busy_o` falls, `chain_o` carries a one-cycle one-hot pulse on that index. A target equal to CH_ID produces no pulse.
- R10: `irq_o` pulses in the cycle in which `busy_o` falls, unless control bit 21 is set.
- R11: When control bit 22 is set, the bytes within the transfer size are reversed between read and write. A halfword has its two bytes swapped, a word has all four reversed, and a byte is unchanged.
- R12: During every bus cycle, `bus_sniff_o` equals control bit 23 and `bus_prio_o` equals control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| trig_i | input | 1 | Start trigger from a peer channel |
| dreq_i | input | NDREQ | Peripheral pacing requests |
| timer_i | input | 4 | Pacing timer ticks |
| busy_o | output | 1 | Channel is running |
| chain_o | output | NCH | One-hot completion trigger to peer channels |
| irq_o | output | 1 | Completion interrupt pulse |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr_o | output | AW | Byte address |
| bus_size_o | output | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata_o | output | 32 | Write data, right-justified |
| bus_prio_o | output | 1 | High-priority flag |
| bus_sniff_o | output | 1 | Sniffer tag for this bus cycle |
| bus_gnt_i | input | 1 | Grant; completes the current bus cycle |
| bus_rdata_i | input | 32 | Read data, valid while a read is granted |

## Verification
The hardest case to reach is a write or trigger that lands while the channel is stalled mid-transfer. Because triggers and writes are ignored while busy, the stall has to be set up from an idle channel. The stimulus first runs the channel through a zero-count launch, which leaves it enabled but idle. It then loads fresh addresses and a count without starting, starts the channel with `trig_i` on a peripheral request that is held low, and fires both an address write and a second trigger into the stall before the request is released. An unused pacing code is also used to park the channel until reset clears it, and random grant gaps stretch every read and write cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} xfer_state_e;

  localparam int CTRL_W   = 24;
  localparam int NTMR     = 4;
  localparam int B_EN     = 0;
  localparam int B_PRIO   = 1;
  localparam int B_SZ     = 2;
  localparam int B_RINC   = 4;
  localparam int B_WINC   = 5;
  localparam int B_CHAIN  = 11;
  localparam int B_REQ    = 15;
  localparam int B_QUIET  = 21;
  localparam int B_SWAP   = 22;
  localparam int B_SNIFF  = 23;
  localparam logic [5:0] REQ_ALWAYS = 6'h3f;
  localparam logic [5:0] REQ_TMR0   = 6'h3b;

  function automatic logic [1:0] norm_size(input logic [1:0] sz);
    return (sz == 2'd3) ? 2'd2 : sz;
  endfunction

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // right-justify to size, optional byte reversal inside the size
  function automatic logic [31:0] lane_fmt(input logic [31:0] d, input logic [1:0] sz,
                                           input logic swap);
    case (sz)
      2'd0:    return {24'b0, d[7:0]};
      2'd1:    return swap ? {16'b0, d[7:0], d[15:8]} : {16'b0, d[15:0]};
      default: return swap ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
  endfunction
endpackage

// File: rtl/dma_pace.sv
module dma_pace
  import dma_chan_pkg::*;
#(
  parameter int NDREQ = 8
) (
  input  logic [5:0]       sel_i,
  input  logic [NDREQ-1:0] dreq_i,
  input  logic [NTMR-1:0]  tmr_i,
  output logic             req_o
);
  always_comb begin
    req_o = 1'b0;
    for (int i = 0; i < NDREQ; i++)
      if (sel_i == 6'(i)) req_o = dreq_i[i];
    for (int i = 0; i < NTMR; i++)
      if (sel_i == REQ_TMR0 + 6'(i)) req_o = tmr_i[i];
    if (sel_i == REQ_ALWAYS) req_o = 1'b1;
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              trig_i,
  input  logic              busy_i,
  input  logic              adv_i,
  output logic [31:0]       rdata_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [31:0]       cnt_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              start_o
);
  logic [AW-1:0]     rd_q, wr_q;
  logic [31:0]       cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr, eff_en;
  logic [AW-1:0]     step;

  assign ctrl_wr = we_i && (addr_i == 2'd3);
  assign eff_en  = ctrl_wr ? wdata_i[B_EN] : ctrl_q[B_EN];
  assign start_o = !busy_i && (ctrl_wr || trig_i) && eff_en;
  assign step    = AW'(size_step(ctrl_q[B_SZ+:2]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else if (!busy_i && we_i) begin
      case (addr_i)
        2'd0:    rd_q   <= wdata_i[AW-1:0];
        2'd1:    wr_q   <= wdata_i[AW-1:0];
        2'd2:    cnt_q  <= wdata_i;
        default: ctrl_q <= wdata_i[CTRL_W-1:0];
      endcase
    end else if (adv_i) begin
      if (ctrl_q[B_RINC]) rd_q <= rd_q + step;
      if (ctrl_q[B_WINC]) wr_q <= wr_q + step;
      cnt_q <= cnt_q - 32'd1;
    end
  end

  always_comb begin
    case (addr_i)
      2'd0:    rdata_o = 32'(rd_q);
      2'd1:    rdata_o = 32'(wr_q);
      2'd2:    rdata_o = cnt_q;
      default: rdata_o = 32'(ctrl_q);
    endcase
  end

  assign rd_addr_o = rd_q;
  assign wr_addr_o = wr_q;
  assign cnt_o     = cnt_q;
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          req_i,
  input  logic          cnt_zero_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [1:0]    size_i,
  input  logic          swap_i,
  input  logic          prio_i,
  input  logic          sniff_i,
  input  logic          bus_gnt_i,
  input  logic [31:0]   bus_rdata_i,
  output logic          busy_o,
  output logic          adv_o,
  output logic          done_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [31:0]   bus_wdata_o,
  output logic          bus_prio_o,
  output logic          bus_sniff_o
);
  xfer_state_e st_q;
  logic [31:0] data_q;
  logic        done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (cnt_zero_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (req_i) begin
            st_q <= ST_RD;
          end
        end
        ST_RD: if (bus_gnt_i) begin
          data_q <= lane_fmt(bus_rdata_i, size_i, swap_i);
          st_q   <= ST_WR;
        end
        default: if (bus_gnt_i) st_q <= ST_WAIT;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign bus_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign bus_we_o    = (st_q == ST_WR);
  assign adv_o       = bus_we_o && bus_gnt_i;
  assign bus_addr_o  = bus_we_o ? wr_addr_i : rd_addr_i;
  assign bus_size_o  = norm_size(size_i);
  assign bus_wdata_o = data_q;
  assign bus_prio_o  = prio_i && bus_req_o;
  assign bus_sniff_o = sniff_i && bus_req_o;
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NDREQ = 8,
  parameter int NCH   = 16,
  parameter int CH_ID = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             trig_i,
  input  logic [NDREQ-1:0] dreq_i,
  input  logic [3:0]       timer_i,
  output logic             busy_o,
  output logic [NCH-1:0]   chain_o,
  output logic             irq_o,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [1:0]       bus_size_o,
  output logic [31:0]      bus_wdata_o,
  output logic             bus_prio_o,
  output logic             bus_sniff_o,
  input  logic             bus_gnt_i,
  input  logic [31:0]      bus_rdata_i
);
  logic [AW-1:0]     rd_addr, wr_addr;
  logic [31:0]       cnt;
  logic [CTRL_W-1:0] ctrl;
  logic              start, adv, done, pace_req, busy;
  logic [3:0]        tgt;

  dma_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .trig_i, .busy_i(busy), .adv_i(adv),
    .rdata_o(reg_rdata_o), .rd_addr_o(rd_addr), .wr_addr_o(wr_addr),
    .cnt_o(cnt), .ctrl_o(ctrl), .start_o(start)
  );

  dma_pace #(.NDREQ(NDREQ)) u_pace (
    .sel_i(ctrl[B_REQ+:6]), .dreq_i, .tmr_i(timer_i), .req_o(pace_req)
  );

  dma_xfer #(.AW(AW)) u_xfer (
    .clk_i, .rst_ni,
    .start_i(start), .req_i(pace_req), .cnt_zero_i(cnt == '0),
    .rd_addr_i(rd_addr), .wr_addr_i(wr_addr),
    .size_i(ctrl[B_SZ+:2]), .swap_i(ctrl[B_SWAP]),
    .prio_i(ctrl[B_PRIO]), .sniff_i(ctrl[B_SNIFF]),
    .bus_gnt_i, .bus_rdata_i,
    .busy_o(busy), .adv_o(adv), .done_o(done),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_size_o,
    .bus_wdata_o, .bus_prio_o, .bus_sniff_o
  );

  assign busy_o = busy;
  assign irq_o  = done && !ctrl[B_QUIET];
  assign tgt    = ctrl[B_CHAIN+:4];

  for (genvar g = 0; g < NCH; g++) begin : g_chain
    if (g == CH_ID) begin : g_self
      assign chain_o[g] = 1'b0;
    end else begin : g_peer
      assign chain_o[g] = done && (tgt == 4'(g));
    end
  end
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW  = 32,
  parameter int NCH = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           busy_o,
  input logic           bus_req_o,
  input logic           bus_we_o,
  input logic           bus_gnt_i,
  input logic [AW-1:0]  bus_addr_o,
  input logic [31:0]    bus_wdata_o,
  input logic [NCH-1:0] chain_o,
  input logic           irq_o,
  input logic           bus_sniff_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o);
  a_r6_write_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o && bus_gnt_i |=> bus_req_o && bus_we_o);
  a_r6_hold_until_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o));
  a_r11_wdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && !bus_gnt_i |=> $stable(bus_wdata_o));
  a_r9_chain_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chain_o));
  a_r9_chain_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chain_o) |-> $fell(busy_o));
  a_r10_irq_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $fell(busy_o));
  a_r12_sniff_on_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_sniff_o |-> bus_req_o);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .bus_req_o(bus_req_o),
  .bus_we_o(bus_we_o), .bus_gnt_i(bus_gnt_i), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .chain_o(chain_o), .irq_o(irq_o),
  .bus_sniff_o(bus_sniff_o)
);

// File: tb/sim_dma_chan_engine.sv
`timescale 1ns/1ps
module sim_dma_chan_engine;
  localparam int NDREQ = 8;
  localparam int NCH   = 16;
  localparam int MYID  = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        trig_i = 1'b0;
  logic [NDREQ-1:0] dreq_i = '0;
  logic [3:0]  timer_i = '0;
  logic        busy_o, irq_o, bus_req_o, bus_we_o, bus_prio_o, bus_sniff_o;
  logic [NCH-1:0] chain_o;
  logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic [1:0]  bus_size_o;
  logic        bus_gnt_i = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] mem [256];
  logic [NCH-1:0] last_chain = '0;

  always #10 clk_i = ~clk_i;

  dma_chan_engine #(.AW(32), .NDREQ(NDREQ), .NCH(NCH), .CH_ID(MYID)) u0 (.*);

  always_comb begin
    logic [7:0] a;
    a = bus_addr_o[7:0];
    bus_rdata_i = {mem[a+8'd3], mem[a+8'd2], mem[a+8'd1], mem[a]};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int          ms = 0;
  logic [31:0] mrd = '0, mwr = '0, mcnt = '0, mdata = '0;
  logic [23:0] mctrl = '0;
  bit          mdone = 1'b0;

  function automatic logic [31:0] fmt(input logic [31:0] d, input int sz, input bit sw);
    logic [31:0] r;
    if (sz == 0) r = d & 32'hff;
    else if (sz == 1) r = sw ? ((d & 32'hff) << 8) | ((d >> 8) & 32'hff) : (d & 32'hffff);
    else if (sw) r = {d[7:0], d[15:8], d[23:16], d[31:24]};
    else r = d;
    return r;
  endfunction

  function automatic bit pace_ok(input int sel);
    if (sel == 63) return 1'b1;
    if (sel >= 59 && sel <= 62) return timer_i[sel-59];
    if (sel < NDREQ) return dreq_i[sel];
    return 1'b0;
  endfunction

  always begin
    @(posedge clk_i);
    cyc++;
    if (bus_req_o && bus_we_o && bus_gnt_i)
      for (int b = 0; b < (1 << bus_size_o); b++)
        mem[8'(bus_addr_o + 32'(b))] = 8'(bus_wdata_o >> (8*b));
    if (!rst_ni) begin
      ms = 0; mrd = 0; mwr = 0; mcnt = 0; mctrl = 0; mdata = 0; mdone = 0;
    end else begin
      int sz, stp;
      bit cw, en;
      sz  = (mctrl[3:2] == 2'd3) ? 2 : int'(mctrl[3:2]);
      stp = 1 << sz;
      mdone = 1'b0;
      case (ms)
        0: begin
          cw = reg_we_i && reg_addr_i == 2'd3;
          en = cw ? reg_wdata_i[0] : mctrl[0];
          if (reg_we_i)
            case (reg_addr_i)
              2'd0: mrd = reg_wdata_i;
              2'd1: mwr = reg_wdata_i;
              2'd2: mcnt = reg_wdata_i;
              default: mctrl = reg_wdata_i[23:0];
            endcase
          if ((cw || trig_i) && en) ms = 1;
        end
        1: if (mcnt == 0) begin ms = 0; mdone = 1'b1; end
           else if (pace_ok(int'(mctrl[20:15]))) ms = 2;
        2: if (bus_gnt_i) begin
             mdata = fmt({mem[8'(mrd+3)], mem[8'(mrd+2)], mem[8'(mrd+1)], mem[8'(mrd)]},
                         sz, mctrl[22]);
             ms = 3;
           end
        default: if (bus_gnt_i) begin
             if (mctrl[4]) mrd = mrd + stp;
             if (mctrl[5]) mwr = mwr + stp;
             mcnt = mcnt - 1;
             ms = 1;
           end
      endcase
    end
    #2;
    if (chain_o != '0) last_chain = chain_o;
    chk("R3/R4 busy", 32'(busy_o), 32'(ms != 0));
    chk("R6 bus_req", 32'(bus_req_o), 32'(ms == 2 || ms == 3));
    chk("R9 chain", 32'(chain_o),
        (mdone && mctrl[14:11] != 4'(MYID)) ? (32'd1 << mctrl[14:11]) : 32'd0);
    chk("R10 irq", 32'(irq_o), 32'(mdone && !mctrl[21]));
    case (reg_addr_i)
      2'd0: chk("R2 readback rd", reg_rdata_o, mrd);
      2'd1: chk("R2 readback wr", reg_rdata_o, mwr);
      2'd2: chk("R2 readback cnt", reg_rdata_o, mcnt);
      default: chk("R2 readback ctrl", reg_rdata_o, {8'b0, mctrl});
    endcase
    if (ms == 2 || ms == 3) begin
      chk("R6 bus_we", 32'(bus_we_o), 32'(ms == 3));
      chk("R8 bus_addr", bus_addr_o, (ms == 2) ? mrd : mwr);
      chk("R7 bus_size", 32'(bus_size_o), (mctrl[3:2] == 2'd3) ? 32'd2 : 32'(mctrl[3:2]));
      chk("R12 prio", 32'(bus_prio_o), 32'(mctrl[1]));
      chk("R12 sniff", 32'(bus_sniff_o), 32'(mctrl[23]));
      if (ms == 3) chk("R7/R11 wdata", bus_wdata_o, mdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  always @(negedge clk_i) begin
    bus_gnt_i <= ($urandom % 4) != 0;
    timer_i   <= {1'b0, (cyc % 5) == 0, 2'b00};
  end

  function automatic logic [31:0] mk(input int sz, input bit ri, input bit wi, input int tgt,
                                     input int sel, input bit quiet, input bit sw,
                                     input bit sn, input bit pr, input bit en);
    return (32'(sn) << 23) | (32'(sw) << 22) | (32'(quiet) << 21) | (32'(sel) << 15) |
           (32'(tgt) << 11) | (32'(wi) << 5) | (32'(ri) << 4) | (32'(sz) << 2) |
           (32'(pr) << 1) | 32'(en);
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic load(input logic [31:0] r, input logic [31:0] w, input logic [31:0] n,
                      input logic [31:0] c);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = r;
    @(negedge clk_i); reg_addr_i = 2'd1; reg_wdata_i = w;
    @(negedge clk_i); reg_addr_i = 2'd2; reg_wdata_i = n;
    @(negedge clk_i); reg_addr_i = 2'd3; reg_wdata_i = c;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (!busy_o) return;
    end
  endtask

  function automatic logic [7:0] init_b(input int i);
    return 8'(i * 7 + 3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL R6 watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_b(i);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    chk("R1 busy after reset", 32'(busy_o), 0);
    for (int a = 0; a < 4; a++) begin
      reg_addr_i = 2'(a); #1;
      chk("R1 reg zero after reset", reg_rdata_o, 0);
    end

    // word copy, both increment, unpaced, chain to 5
    last_chain = '0;
    load(32'h10, 32'h80, 4, mk(2, 1, 1, 5, 63, 0, 0, 0, 0, 1));
    wait_idle();
    for (int i = 0; i < 16; i++) chk("R6 word copy data", 32'(mem[8'h80+i]), 32'(init_b(16+i)));
    chk("R9 chain target 5", 32'(last_chain), 32'h20);

    // halfword, read inc, write fixed, byte swap, timer 2 pacing, size code 1
    load(32'h20, 32'hA0, 3, mk(1, 1, 0, 7, 8'h3d, 0, 1, 0, 1, 1));
    wait_idle();
    chk("R11 swapped halfword lo", 32'(mem[8'hA0]), 32'(init_b(8'h25)));
    chk("R8 fixed write hi", 32'(mem[8'hA1]), 32'(init_b(8'h24)));
    chk("R8 fixed write untouched", 32'(mem[8'hA2]), 32'(init_b(8'hA2)));

    // byte, read fixed, write inc, self chain, quiet, sniff, size code 3 later
    last_chain = '0;
    load(32'h30, 32'hC0, 3, mk(0, 0, 1, MYID, 63, 1, 1, 1, 0, 1));
    wait_idle();
    for (int i = 0; i < 3; i++) chk("R8 fixed read byte", 32'(mem[8'hC0+i]), 32'(init_b(8'h30)));
    chk("R9 self chain silent", 32'(last_chain), 0);

    // size code 3 acts as word, swap on
    load(32'h40, 32'hD0, 1, mk(3, 1, 1, 2, 63, 0, 1, 0, 0, 1));
    wait_idle();
    chk("R7 size3 word swap b0", 32'(mem[8'hD0]), 32'(init_b(8'h43)));
    chk("R7 size3 word swap b3", 32'(mem[8'hD3]), 32'(init_b(8'h40)));

    // zero count completes at once
    load(32'h00, 32'h00, 0, mk(2, 1, 1, 1, 63, 0, 0, 0, 0, 1));
    wait_idle();
    chk("R6 zero count idle", 32'(busy_o), 0);

    // enable clear: neither ctrl write nor trig starts
    wr_reg(2'd3, mk(2, 1, 1, 1, 3, 0, 0, 0, 0, 0));
    @(negedge clk_i); trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    @(negedge clk_i);
    chk("R3 no start when disabled", 32'(busy_o), 0);

    // enable via zero-count run, then trig start on dreq 3
    wr_reg(2'd2, 0);
    wr_reg(2'd3, mk(2, 1, 1, 1, 3, 0, 0, 0, 0, 1));
    wait_idle();
    wr_reg(2'd0, 32'h40);
    wr_reg(2'd1, 32'hE0);
    wr_reg(2'd2, 2);
    @(negedge clk_i);
    chk("R3 load without start", 32'(busy_o), 0);
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    chk("R3 trig start", 32'(busy_o), 1);
    repeat (5) @(negedge clk_i);
    chk("R5 dreq low stalls", 32'(bus_req_o), 0);
    wr_reg(2'd0, 32'h00);
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    dreq_i[3] = 1'b1;
    wait_idle();
    dreq_i[3] = 1'b0;
    reg_addr_i = 2'd0; #1;
    chk("R4 ignored write while busy", reg_rdata_o, 32'h48);
    chk("R6 trig copy data", 32'(mem[8'hE7]), 32'(init_b(8'h47)));

    // unassigned pacing code never runs; reset recovers
    load(32'h10, 32'h60, 1, mk(2, 1, 1, 1, 8'h30, 0, 0, 0, 0, 1));
    repeat (40) @(negedge clk_i);
    chk("R5 unused code stalls", 32'(busy_o), 1);
    chk("R5 unused code no bus", 32'(bus_req_o), 0);
    rst_ni = 1'b0;
    @(negedge clk_i); #1;
    chk("R1 reset clears busy", 32'(busy_o), 0);
    reg_addr_i = 2'd3; #1;
    chk("R1 reset clears ctrl", reg_rdata_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule